// File: doc/BRIEF.md
# Monitor Channel Transmit Handshake Controller

This block is the transmitting half of one monitor channel on a frame-based serial control link. A host places message bytes, one at a time, into a single-byte holding register. Once per frame the block presents an outgoing monitor byte together with a frame-valid bit (MX). It also takes one sample of the receiver's acknowledge bit (MR). From those samples it decides whether to repeat the current byte, ask the host for the next one, close the message, or give up because the receiver has aborted.

The host sees three flags. The buffer-empty flag asks for the next byte. The abort flag reports that the receiver cancelled the message. A pending bit shows that an end-of-message request has been written and not yet acted on. The same end-of-message request also serves as a forced re-initialisation when the block is in the middle of a transfer. An interrupt line merges the buffer-empty flag and the abort flag under a single enable. Placing the byte into a time slot and serialising it are done outside this block. The block only needs a one-cycle strobe at each frame boundary.

Top module: `mon_tx_hs`

## Requirements
- R1: While the channel is disabled, the outputs are monitor byte 0xFF and MX=1, and all flags are 0. In the clock after the channel is enabled, the buffer-empty flag becomes 1. Idle keeps sending 0xFF with MX=1.
- R2: A host byte write clears the buffer-empty flag and the abort flag. At the next frame strobe from idle, the written byte is sent with MX=0.
- R3: While a byte is unacknowledged, every following frame repeats the same byte with MX=0 and buffer-empty stays 0.
- R4: For the first byte of a message, buffer-empty is set only when MR is 1 at one frame strobe and 0 at the next (a high-to-low edge). MR=1 alone does not set it.
- R5: For every later byte, buffer-empty is set at the first frame strobe at which MR=1 is sampled.
- R6: While buffer-empty is 1 after an acknowledge, the last byte is held with MX=0 for as many frames as the host takes. At the frame strobe after a write, the new byte is sent with MX=0.
- R7: The end-of-message bit is written while buffer-empty=1 after an acknowledged byte, and MR is sampled 0. The block then sends 0xFF with MX=1 for two frames and returns to idle. The end-of-message bit then reads 0.
- R8: The end-of-message bit is written during an active transfer that is not waiting for the host. At the next frame strobe the block enters idle (0xFF, MX=1) and sets buffer-empty, and the bit clears.
- R9: MR is sampled 1 at two consecutive frame strobes during an active transfer. This is an abort: the block sends 0xFF with MX=1, then idles, and sets buffer-empty and the abort flag.
- R10: The interrupt output equals the interrupt enable ANDed with the OR of buffer-empty and the abort flag.
- R11: Monitor byte and MX change only in the clock after a frame strobe or after the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel enable; low holds the block in idle with flags cleared |
| frame_stb | input | 1 | One-cycle pulse at each frame boundary |
| mr_in | input | 1 | Receiver acknowledge bit of the current frame |
| host_wr | input | 1 | Host write strobe for the data register |
| host_data | input | DATA_W | Byte written by the host |
| eom_wr | input | 1 | Host write that sets the end-of-message / re-initialise bit |
| obe_irq_en | input | 1 | Interrupt enable for buffer-empty and abort |
| mon_byte | output | DATA_W | Monitor byte for the current frame |
| mx_out | output | 1 | MX bit for the current frame (0 = byte valid) |
| obe_flag | output | 1 | Buffer-empty flag (host may write the next byte) |
| abort_flag | output | 1 | Receiver abort seen |
| eom_pend | output | 1 | End-of-message bit not yet consumed |
| irq | output | 1 | Interrupt request |

## Verification
The main handshake runs as a sweep over a six-byte message with computed byte values. Each byte gets a different number of unacknowledged frames and host-delay frames. This separates repeat-on-no-ack from hold-while-host-late, and first-byte edge detection from later-byte level detection. Single MR pulses on the first byte show that a level alone does not release it. Two-frame MR highs in different states separate abort from acknowledge. The end-of-message request is issued in the waiting state and in the sending state, which separates a clean close from a forced re-initialisation. The interrupt mask is toggled with each flag set.

// File: rtl/mtx_pkg.sv
// Shared types for the monitor-channel transmit controller.
package mtx_pkg;

    // Transmit handshake states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // sending idle pattern, no message
        ST_FIRST = 3'd1,   // first byte out, waiting for MR high-to-low
        ST_NEXT  = 3'd2,   // later byte out, waiting for MR=1
        ST_WAIT  = 3'd3,   // byte acknowledged, waiting for host data
        ST_EOT   = 3'd4    // sending end-of-transmission frames
    } mtx_state_e;

endpackage

// File: rtl/mtx_mr_sense.sv
// Samples the receiver acknowledge bit once per frame and derives the
// per-frame events the handshake needs: a high-to-low edge across two
// frames and a high level held over two frames.
// Assumes frame_stb is a single-cycle pulse and mr_in is valid with it.
module mtx_mr_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic frame_stb,
    input  logic mr_in,
    output logic mr_now,
    output logic mr_fall,
    output logic mr_twice
);

    logic mr_q;

    // Remember the MR value of the previous frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            mr_q <= 1'b0;
        end else if (frame_stb) begin
            mr_q <= mr_in;
        end
    end

    // Frame events, valid only in the strobe cycle.
    always_comb begin
        mr_now   = frame_stb & mr_in;
        mr_fall  = frame_stb & mr_q & ~mr_in;
        mr_twice = frame_stb & mr_q & mr_in;
    end

endmodule

// File: rtl/mtx_ctrl.sv
// Transmit handshake state machine. It acts only on frame strobes and
// produces the monitor byte and MX for the next frame, plus single-cycle
// requests to the flag block.
// Assumes the flag block applies set_obe/set_abort/clr_eom in the same
// cycle and that obe reflects host writes seen before the strobe.
module mtx_ctrl
    import mtx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int EOT_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_stb,
    input  logic              mr_now,
    input  logic              mr_fall,
    input  logic              mr_twice,
    input  logic              obe,
    input  logic              eom,
    input  logic [DATA_W-1:0] buf_data,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_mx,
    output logic              set_obe,
    output logic              set_abort,
    output logic              clr_eom
);

    localparam int                CNT_W    = $clog2(EOT_FRAMES + 1);
    localparam logic [DATA_W-1:0] IDLE_PAT = {DATA_W{1'b1}};
    localparam logic [CNT_W-1:0]  EOT_LAST = CNT_W'(EOT_FRAMES - 1);

    mtx_state_e        state_q, state_d;
    logic [DATA_W-1:0] byte_q, byte_d;
    logic              mx_q, mx_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              active;

    // A message is in progress in these states.
    always_comb begin
        active = (state_q == ST_FIRST) || (state_q == ST_NEXT) ||
                 (state_q == ST_WAIT);
    end

    // Next-state and request logic, evaluated at each frame strobe.
    always_comb begin
        state_d   = state_q;
        byte_d    = byte_q;
        mx_d      = mx_q;
        cnt_d     = cnt_q;
        set_obe   = 1'b0;
        set_abort = 1'b0;
        clr_eom   = 1'b0;
        if (frame_stb) begin
            if (active && mr_twice) begin
                // receiver abort: close the message
                state_d   = ST_EOT;
                byte_d    = IDLE_PAT;
                mx_d      = 1'b1;
                cnt_d     = '0;
                set_obe   = 1'b1;
                set_abort = 1'b1;
                clr_eom   = eom;
            end else if (eom && state_q == ST_WAIT && obe) begin
                // clean close once the acknowledge has ended
                if (!mr_now) begin
                    state_d = ST_EOT;
                    byte_d  = IDLE_PAT;
                    mx_d    = 1'b1;
                    cnt_d   = '0;
                    clr_eom = 1'b1;
                end
            end else if (eom && active) begin
                // forced re-initialisation
                state_d = ST_IDLE;
                byte_d  = IDLE_PAT;
                mx_d    = 1'b1;
                set_obe = 1'b1;
                clr_eom = 1'b1;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        clr_eom = eom;
                        if (!obe) begin
                            state_d = ST_FIRST;
                            byte_d  = buf_data;
                            mx_d    = 1'b0;
                        end
                    end
                    ST_FIRST: begin
                        if (mr_fall) begin
                            state_d = ST_WAIT;
                            set_obe = 1'b1;
                        end
                    end
                    ST_NEXT: begin
                        if (mr_now) begin
                            state_d = ST_WAIT;
                            set_obe = 1'b1;
                        end
                    end
                    ST_WAIT: begin
                        if (!obe) begin
                            state_d = ST_NEXT;
                            byte_d  = buf_data;
                            mx_d    = 1'b0;
                        end
                    end
                    ST_EOT: begin
                        clr_eom = eom;
                        if (cnt_q == EOT_LAST) begin
                            state_d = ST_IDLE;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        state_d = ST_IDLE;
                        byte_d  = IDLE_PAT;
                        mx_d    = 1'b1;
                    end
                endcase
            end
        end
    end

    // State and output registers; disable forces idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q <= ST_IDLE;
            byte_q  <= IDLE_PAT;
            mx_q    <= 1'b1;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            mx_q    <= mx_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered outputs for the current frame.
    always_comb begin
        tx_byte = byte_q;
        tx_mx   = mx_q;
    end

endmodule

// File: rtl/mtx_flags.sv
// Host-visible flags: data holding register, buffer-empty, abort and the
// self-clearing end-of-message bit, plus the merged interrupt.
// Assumes host_wr and eom_wr are single-cycle write strobes. A host write
// takes priority over a same-cycle buffer-empty set, and an end-of-message
// write takes priority over a same-cycle clear.
module mtx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              eom_wr,
    input  logic              obe_irq_en,
    input  logic              set_obe,
    input  logic              set_abort,
    input  logic              clr_eom,
    output logic [DATA_W-1:0] buf_data,
    output logic              obe,
    output logic              abort,
    output logic              eom,
    output logic              irq
);

    logic en_q;
    logic en_rise;

    // Track enable to find the enabling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= enable;
        end
    end

    // The enabling edge requests the first byte.
    always_comb begin
        en_rise = enable & ~en_q;
    end

    // Data holding register loaded by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_data <= '0;
        end else if (host_wr) begin
            buf_data <= host_data;
        end
    end

    // Buffer-empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            obe <= 1'b0;
        end else if (host_wr) begin
            obe <= 1'b0;
        end else if (set_obe || en_rise) begin
            obe <= 1'b1;
        end
    end

    // Abort flag, cleared together with buffer-empty.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            abort <= 1'b0;
        end else if (host_wr) begin
            abort <= 1'b0;
        end else if (set_abort) begin
            abort <= 1'b1;
        end
    end

    // End-of-message bit, cleared by the state machine once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            eom <= 1'b0;
        end else if (eom_wr) begin
            eom <= 1'b1;
        end else if (clr_eom) begin
            eom <= 1'b0;
        end
    end

    // Interrupt merges both flags under one enable.
    always_comb begin
        irq = obe_irq_en & (obe | abort);
    end

endmodule

// File: rtl/mon_tx_hs.sv
// Top of the monitor-channel transmit handshake controller. It wires the
// MR frame sampler, the handshake state machine and the host flag block.
// Assumes one frame_stb pulse per frame with mr_in valid in that cycle.
module mon_tx_hs #(
    parameter int DATA_W     = 8,
    parameter int EOT_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_stb,
    input  logic              mr_in,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              eom_wr,
    input  logic              obe_irq_en,
    output logic [DATA_W-1:0] mon_byte,
    output logic              mx_out,
    output logic              obe_flag,
    output logic              abort_flag,
    output logic              eom_pend,
    output logic              irq
);

    logic              mr_now, mr_fall, mr_twice;
    logic              set_obe, set_abort, clr_eom;
    logic [DATA_W-1:0] buf_data;

    mtx_mr_sense u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .frame_stb (frame_stb),
        .mr_in     (mr_in),
        .mr_now    (mr_now),
        .mr_fall   (mr_fall),
        .mr_twice  (mr_twice)
    );

    mtx_ctrl #(
        .DATA_W     (DATA_W),
        .EOT_FRAMES (EOT_FRAMES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .frame_stb (frame_stb),
        .mr_now    (mr_now),
        .mr_fall   (mr_fall),
        .mr_twice  (mr_twice),
        .obe       (obe_flag),
        .eom       (eom_pend),
        .buf_data  (buf_data),
        .tx_byte   (mon_byte),
        .tx_mx     (mx_out),
        .set_obe   (set_obe),
        .set_abort (set_abort),
        .clr_eom   (clr_eom)
    );

    mtx_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .host_wr    (host_wr),
        .host_data  (host_data),
        .eom_wr     (eom_wr),
        .obe_irq_en (obe_irq_en),
        .set_obe    (set_obe),
        .set_abort  (set_abort),
        .clr_eom    (clr_eom),
        .buf_data   (buf_data),
        .obe        (obe_flag),
        .abort      (abort_flag),
        .eom        (eom_pend),
        .irq        (irq)
    );

endmodule

// File: rtl/mon_tx_hs_chk.sv
// Port-level protocol checks for mon_tx_hs, attached with bind.
module mon_tx_hs_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              frame_stb,
    input logic              host_wr,
    input logic [DATA_W-1:0] mon_byte,
    input logic              mx_out,
    input logic              obe_flag,
    input logic              abort_flag
);

    // R1: disabled channel sends the idle pattern with MX=1
    a_r1_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (mx_out && mon_byte == {DATA_W{1'b1}}));

    // R2: a host write leaves buffer-empty clear
    a_r2_write_clears_obe: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && enable) |=> !obe_flag);

    // R2: buffer-empty falls only by a host write or by disabling
    a_r2_obe_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obe_flag) |-> ($past(host_wr) || !$past(enable)));

    // R9: abort is always reported together with buffer-empty
    a_r9_abort_with_obe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_flag) |-> obe_flag);

    // R11: no frame strobe, no change of the frame outputs
    a_r11_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && enable) |=> ($stable(mx_out) && $stable(mon_byte)));

endmodule

bind mon_tx_hs mon_tx_hs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .frame_stb  (frame_stb),
    .host_wr    (host_wr),
    .mon_byte   (mon_byte),
    .mx_out     (mx_out),
    .obe_flag   (obe_flag),
    .abort_flag (abort_flag)
);

// File: tb/mon_tx_hs_test.sv
module mon_tx_hs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       frame_stb = 1'b0;
    logic       mr_in = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       eom_wr = 1'b0;
    logic       obe_irq_en = 1'b1;
    logic [7:0] mon_byte;
    logic       mx_out, obe_flag, abort_flag, eom_pend, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mon_tx_hs uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .frame_stb  (frame_stb),
        .mr_in      (mr_in),
        .host_wr    (host_wr),
        .host_data  (host_data),
        .eom_wr     (eom_wr),
        .obe_irq_en (obe_irq_en),
        .mon_byte   (mon_byte),
        .mx_out     (mx_out),
        .obe_flag   (obe_flag),
        .abort_flag (abort_flag),
        .eom_pend   (eom_pend),
        .irq        (irq)
    );

    task automatic chk_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk_frame(string req, logic [7:0] exp_b, logic exp_mx, logic exp_obe);
        checks++;
        if (mon_byte !== exp_b || mx_out !== exp_mx || obe_flag !== exp_obe) begin
            errors++;
            $display("FAIL %s byte/mx/obe actual %h/%0b/%0b expected %h/%0b/%0b",
                     req, mon_byte, mx_out, obe_flag, exp_b, exp_mx, exp_obe);
        end
    endtask

    // One frame: present MR with the strobe, then settle.
    task automatic frame(logic mr);
        mr_in = mr;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        mr_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_write(logic [7:0] b);
        host_wr = 1'b1;
        host_data = b;
        @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic eom_write();
        eom_wr = 1'b1;
        @(negedge clk);
        eom_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset / disabled state
        chk_frame("R1", 8'hFF, 1'b1, 1'b0);
        chk_bit("R1", "abort", abort_flag, 1'b0);
        enable = 1'b1;
        @(negedge clk);
        chk_frame("R1", 8'hFF, 1'b1, 1'b1);
        chk_bit("R10", "irq obe", irq, 1'b1);
        obe_irq_en = 1'b0;
        #1;
        chk_bit("R10", "irq masked", irq, 1'b0);
        obe_irq_en = 1'b1;
        frame(1'b0);
        chk_frame("R1", 8'hFF, 1'b1, 1'b1);

        // First-byte release: MR level alone is not enough (R4)
        host_write(8'hA5);
        chk_frame("R2", 8'hFF, 1'b1, 1'b0);
        chk_bit("R10", "irq clear", irq, 1'b0);
        frame(1'b0);
        chk_frame("R2", 8'hA5, 1'b0, 1'b0);
        frame(1'b1);
        chk_frame("R4", 8'hA5, 1'b0, 1'b0);
        frame(1'b0);
        chk_frame("R4", 8'hA5, 1'b0, 1'b1);
        // abandon this message by re-initialising from the waiting state
        host_write(8'h77);
        eom_write();
        chk_bit("R8", "eom pending", eom_pend, 1'b1);
        frame(1'b0);
        chk_frame("R8", 8'hFF, 1'b1, 1'b1);
        chk_bit("R8", "eom cleared", eom_pend, 1'b0);

        // Sweep: six-byte message, varied no-ack and host-delay frames.
        for (int i = 0; i < 6; i++) begin
            automatic logic [7:0] b = 8'((i * 37 + 5) ^ 8'h5C);
            host_write(b);
            frame(1'b0);
            chk_frame((i == 0) ? "R2" : "R6", b, 1'b0, 1'b0);
            for (int k = 0; k < (i % 3) + 1; k++) begin
                frame(1'b0);
                chk_frame("R3", b, 1'b0, 1'b0);
            end
            if (i == 0) begin
                frame(1'b1);
                chk_frame("R4", b, 1'b0, 1'b0);
                frame(1'b0);
                chk_frame("R4", b, 1'b0, 1'b1);
            end else begin
                frame(1'b1);
                chk_frame("R5", b, 1'b0, 1'b1);
                frame(1'b0);
                chk_frame("R6", b, 1'b0, 1'b1);
            end
            for (int k = 0; k < i % 2; k++) begin
                frame(1'b0);
                chk_frame("R6", b, 1'b0, 1'b1);
            end
        end
        // Clean close (R7)
        eom_write();
        chk_frame("R11", 8'h5C ^ 8'((5 * 37 + 5)), 1'b0, 1'b1);
        frame(1'b0);
        chk_frame("R7", 8'hFF, 1'b1, 1'b1);
        chk_bit("R7", "eom cleared", eom_pend, 1'b0);
        frame(1'b0);
        chk_frame("R7", 8'hFF, 1'b1, 1'b1);
        frame(1'b0);
        chk_frame("R7", 8'hFF, 1'b1, 1'b1);
        chk_bit("R7", "no abort", abort_flag, 1'b0);

        // Abort during first byte (R9)
        host_write(8'h11);
        frame(1'b0);
        chk_frame("R2", 8'h11, 1'b0, 1'b0);
        frame(1'b1);
        chk_frame("R9", 8'h11, 1'b0, 1'b0);
        frame(1'b1);
        chk_frame("R9", 8'hFF, 1'b1, 1'b1);
        chk_bit("R9", "abort", abort_flag, 1'b1);
        obe_irq_en = 1'b0;
        #1;
        chk_bit("R10", "irq masked abort", irq, 1'b0);
        obe_irq_en = 1'b1;
        #1;
        chk_bit("R10", "irq abort", irq, 1'b1);
        frame(1'b0);
        frame(1'b0);
        chk_frame("R9", 8'hFF, 1'b1, 1'b1);
        host_write(8'h22);
        chk_bit("R2", "abort cleared", abort_flag, 1'b0);

        // Abort after an acknowledge on a later byte (R9)
        frame(1'b0);
        chk_frame("R2", 8'h22, 1'b0, 1'b0);
        frame(1'b1);
        frame(1'b0);
        chk_frame("R4", 8'h22, 1'b0, 1'b1);
        host_write(8'h33);
        frame(1'b0);
        chk_frame("R6", 8'h33, 1'b0, 1'b0);
        frame(1'b1);
        chk_frame("R5", 8'h33, 1'b0, 1'b1);
        frame(1'b1);
        chk_frame("R9", 8'hFF, 1'b1, 1'b1);
        chk_bit("R9", "abort", abort_flag, 1'b1);
        frame(1'b0);
        frame(1'b0);

        // Forced re-init while sending a byte (R8)
        host_write(8'h44);
        frame(1'b0);
        chk_frame("R2", 8'h44, 1'b0, 1'b0);
        eom_write();
        chk_frame("R11", 8'h44, 1'b0, 1'b0);
        frame(1'b0);
        chk_frame("R8", 8'hFF, 1'b1, 1'b1);
        chk_bit("R8", "eom cleared", eom_pend, 1'b0);

        // Disable mid-transfer (R1)
        host_write(8'h55);
        frame(1'b0);
        chk_frame("R2", 8'h55, 1'b0, 1'b0);
        enable = 1'b0;
        @(negedge clk);
        chk_frame("R1", 8'hFF, 1'b1, 1'b0);
        frame(1'b1);
        chk_frame("R1", 8'hFF, 1'b1, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule